// File: doc/BRIEF.md
# Optical-Drive Host Register Window

This block is the host-facing register window of an optical-drive controller. The host sees four byte-wide ports. Port 0 is an index/status register. Its two low bits choose one of four register banks. The meaning of a read or write on ports 1 to 3 depends on the selected bank. Behind the ports sit several resources:

- a command register and a request register, each of which sends a one-cycle strobe to the drive side;
- a parameter FIFO, which the host fills and the drive side drains;
- a response FIFO and a data FIFO, which the drive side fills and the host drains;
- an interrupt enable register;
- an interrupt flag register, set by the drive and cleared by the host with write-one-to-clear;
- four cross-mix audio volume values.

The host writes the four volume values into staging registers. They reach the active volume outputs only when the host writes an apply bit. This lets all four values change on the same clock edge. Read data on `host_rdata` is combinational. A FIFO pop caused by a host read takes effect at the clock edge that ends the read cycle.

Top module: `odc_host_regs`

## Requirements
- R1: After reset, the bank is 0, the status port reads 0x18, every volume output is 0, and `irq`, `cmd_valid` and `req_valid` are low.
- R2: A write to port 0 loads bits 1:0 into the bank index, and the other written bits have no effect. Status bits 1:0 read back the current bank.
- R3: The status byte is read-only. Bit 2 is response FIFO full. Bit 3 is parameter FIFO empty. Bit 4 is parameter FIFO not full. Bit 5 is response FIFO not empty. Bit 6 is data FIFO not empty. Bit 7 is data FIFO full.
- R4: A port 1 write in bank 0 raises `cmd_valid` for exactly the next cycle, with the written byte on `cmd_byte`. A port 1 write in bank 1 or bank 2 has no effect.
- R5: A port 2 write in bank 0 pushes the parameter FIFO (16 bytes deep). The drive side pops it in order through `par_pop`/`par_byte`. Pushes into a full FIFO are dropped, and `par_byte` is 0 when the FIFO is empty.
- R6: A port 1 read in any bank returns the response FIFO head and pops it. The FIFO is 16 bytes deep and is filled by `rsp_push`. A full FIFO drops pushes, and a read of the empty FIFO returns 0.
- R7: A port 2 read in any bank returns the data FIFO head and pops it. The FIFO is 32 bytes deep and is filled by `dat_push`. A full FIFO drops pushes, and a read of the empty FIFO returns 0.
- R8: A port 2 write in bank 1 loads bits 4:0 into the interrupt enable register. A port 3 read in bank 0 or bank 2 returns the enable register, with bits 7:5 reading 0.
- R9: A bit of `irq_set` sets the matching flag bit. A port 3 write in bank 1 clears each flag bit whose written bit 4:0 is 1, and a set in the same cycle wins. A port 3 read in bank 1 or bank 3 returns the flags, with bits 7:5 reading 0.
- R10: `irq` is high exactly while some flag bit and its enable bit are both 1.
- R11: Staging writes go to the following volumes:
  - port 2 in bank 2 sets left-to-left;
  - port 3 in bank 2 sets left-to-right;
  - port 2 in bank 3 sets right-to-left;
  - port 1 in bank 3 sets right-to-right.

  All four active outputs take their staged values on the edge of a port 3 write in bank 3 that has bit 5 set. At any other time they hold.
- R12: A port 3 write in bank 0 raises `req_valid` for exactly the next cycle, with the written byte on `req_byte`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Host port number 0..3 |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (pops FIFOs on ports 1 and 2) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected port and bank |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Last command byte |
| req_valid | output | 1 | One-cycle request strobe |
| req_byte | output | 8 | Last request byte |
| par_pop | input | 1 | Drive side pops the parameter FIFO |
| par_avail | output | 1 | Parameter FIFO holds data |
| par_byte | output | 8 | Parameter FIFO head, 0 when empty |
| rsp_push | input | 1 | Drive side pushes a response byte |
| rsp_byte | input | 8 | Response byte |
| dat_push | input | 1 | Drive side pushes a data byte |
| dat_byte | input | 8 | Data byte |
| irq_set | input | 5 | Drive side flag set pulses |
| irq | output | 1 | Interrupt request |
| vol_ll | output | 8 | Active left-to-left volume |
| vol_lr | output | 8 | Active left-to-right volume |
| vol_rl | output | 8 | Active right-to-left volume |
| vol_rr | output | 8 | Active right-to-right volume |

## Verification
A bank register that holds the wrong value misroutes the very next access. A write to port 1 or 3 then drives the wrong strobe or stages the wrong volume, and a port 3 read returns flags instead of the enable register. All of this shows up within one access. A drifting FIFO pointer or count appears on the next pop as a wrong or missing byte, and in the status bits. A staging or apply fault is invisible until the next apply write, so the stimulus applies volumes often and checks all four outputs after every operation. An interrupt flag that is stuck set or stuck clear shows on `irq` one cycle after the enable or clear write that exposes it.

// File: rtl/odc_pkg.sv
package odc_pkg;

    // Register bank selected by the index bits of port 0
    typedef enum logic [1:0] {
        BK_CTRL = 2'd0,
        BK_IRQ  = 2'd1,
        BK_MIXA = 2'd2,
        BK_MIXB = 2'd3
    } bank_e;

    localparam logic [1:0] PORT_IDX = 2'd0;
    localparam logic [1:0] PORT_A   = 2'd1;
    localparam logic [1:0] PORT_B   = 2'd2;
    localparam logic [1:0] PORT_C   = 2'd3;

    localparam int BYTE_W    = 8;
    localparam int IRQ_W     = 5;
    localparam int APPLY_BIT = 5;

    // Volume lane order
    localparam int MIX_LL = 0;
    localparam int MIX_LR = 1;
    localparam int MIX_RL = 2;
    localparam int MIX_RR = 3;
    localparam int MIX_N  = 4;

endpackage

// File: rtl/odc_byte_fifo.sv
module odc_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;   // overflow is dropped
    assign do_pop  = pop && !empty;   // underflow is harmless
    assign head    = empty ? '0 : mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) begin
                wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            end
            if (do_pop) begin
                rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/odc_irq_ctrl.sv
module odc_irq_ctrl #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_in,
    input  logic         en_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] flag_q,
    output logic         irq
);
    logic [W-1:0] clr_mask;
    logic [W-1:0] flag_d;

    always_comb begin
        clr_mask = clr_we ? wdata : '0;
        // a set pulse in the same cycle wins over the clear
        flag_d   = (flag_q & ~clr_mask) | set_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            flag_q <= '0;
        end else begin
            flag_q <= flag_d;
            if (en_we) begin
                en_q <= wdata;
            end
        end
    end

    assign irq = |(flag_q & en_q);

endmodule

// File: rtl/odc_mix_vol.sv
module odc_mix_vol #(
    parameter int LANES = 4,
    parameter int W     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          stage_we,
    input  logic [W-1:0]              wdata,
    input  logic                      apply,
    output logic [LANES-1:0][W-1:0]   vol
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [W-1:0] stage_q;
        logic [W-1:0] act_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q <= '0;
            end else if (stage_we[i]) begin
                stage_q <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_q <= '0;
            end else if (apply) begin
                act_q <= stage_q;
            end
        end

        assign vol[i] = act_q;
    end

endmodule

// File: rtl/odc_host_regs.sv
module odc_host_regs
    import odc_pkg::*;
#(
    parameter int PAR_DEPTH = 16,
    parameter int RSP_DEPTH = 16,
    parameter int DAT_DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       host_sel,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    output logic             cmd_valid,
    output logic [7:0]       cmd_byte,
    output logic             req_valid,
    output logic [7:0]       req_byte,
    input  logic             par_pop,
    output logic             par_avail,
    output logic [7:0]       par_byte,
    input  logic             rsp_push,
    input  logic [7:0]       rsp_byte,
    input  logic             dat_push,
    input  logic [7:0]       dat_byte,
    input  logic [4:0]       irq_set,
    output logic             irq,
    output logic [7:0]       vol_ll,
    output logic [7:0]       vol_lr,
    output logic [7:0]       vol_rl,
    output logic [7:0]       vol_rr
);
    // ---------------------------------------------------------------
    // Bank state register
    // ---------------------------------------------------------------
    bank_e bank_q;
    logic  idx_we;

    assign idx_we = host_wr && (host_sel == PORT_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= BK_CTRL;
        end else if (idx_we) begin
            bank_q <= bank_e'(host_wdata[1:0]);
        end
    end

    // ---------------------------------------------------------------
    // Write decode by bank
    // ---------------------------------------------------------------
    logic             wr_a, wr_b, wr_c;
    logic             cmd_we, req_we, par_push, en_we, clr_we, apply;
    logic [MIX_N-1:0] stage_we;

    assign wr_a = host_wr && (host_sel == PORT_A);
    assign wr_b = host_wr && (host_sel == PORT_B);
    assign wr_c = host_wr && (host_sel == PORT_C);

    always_comb begin
        cmd_we   = 1'b0;
        req_we   = 1'b0;
        par_push = 1'b0;
        en_we    = 1'b0;
        clr_we   = 1'b0;
        apply    = 1'b0;
        stage_we = '0;
        unique case (bank_q)
            BK_CTRL: begin
                cmd_we   = wr_a;
                par_push = wr_b;
                req_we   = wr_c;
            end
            BK_IRQ: begin
                en_we  = wr_b;
                clr_we = wr_c;
            end
            BK_MIXA: begin
                stage_we[MIX_LL] = wr_b;
                stage_we[MIX_LR] = wr_c;
            end
            BK_MIXB: begin
                stage_we[MIX_RR] = wr_a;
                stage_we[MIX_RL] = wr_b;
                apply            = wr_c && host_wdata[APPLY_BIT];
            end
        endcase
    end

    // ---------------------------------------------------------------
    // Drive-side strobes
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
            req_valid <= 1'b0;
            req_byte  <= '0;
        end else begin
            cmd_valid <= cmd_we;
            req_valid <= req_we;
            if (cmd_we) begin
                cmd_byte <= host_wdata;
            end
            if (req_we) begin
                req_byte <= host_wdata;
            end
        end
    end

    // ---------------------------------------------------------------
    // FIFOs
    // ---------------------------------------------------------------
    logic       rsp_pop, dat_pop;
    logic [7:0] rsp_head, dat_head;
    logic       par_empty, par_full, rsp_empty, rsp_full, dat_empty, dat_full;

    assign rsp_pop = host_rd && (host_sel == PORT_A);
    assign dat_pop = host_rd && (host_sel == PORT_B);

    odc_byte_fifo #(.DEPTH(PAR_DEPTH), .W(BYTE_W)) u_par_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (par_push),
        .push_data (host_wdata),
        .pop       (par_pop),
        .head      (par_byte),
        .empty     (par_empty),
        .full      (par_full)
    );

    odc_byte_fifo #(.DEPTH(RSP_DEPTH), .W(BYTE_W)) u_rsp_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rsp_push),
        .push_data (rsp_byte),
        .pop       (rsp_pop),
        .head      (rsp_head),
        .empty     (rsp_empty),
        .full      (rsp_full)
    );

    odc_byte_fifo #(.DEPTH(DAT_DEPTH), .W(BYTE_W)) u_dat_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (dat_push),
        .push_data (dat_byte),
        .pop       (dat_pop),
        .head      (dat_head),
        .empty     (dat_empty),
        .full      (dat_full)
    );

    assign par_avail = !par_empty;

    // ---------------------------------------------------------------
    // Interrupt enable / flags
    // ---------------------------------------------------------------
    logic [IRQ_W-1:0] irq_en, irq_flag;

    odc_irq_ctrl #(.W(IRQ_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_in (irq_set),
        .en_we  (en_we),
        .clr_we (clr_we),
        .wdata  (host_wdata[IRQ_W-1:0]),
        .en_q   (irq_en),
        .flag_q (irq_flag),
        .irq    (irq)
    );

    // ---------------------------------------------------------------
    // Staged cross-mix volumes
    // ---------------------------------------------------------------
    logic [MIX_N-1:0][BYTE_W-1:0] vol;

    odc_mix_vol #(.LANES(MIX_N), .W(BYTE_W)) u_mix (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage_we (stage_we),
        .wdata    (host_wdata),
        .apply    (apply),
        .vol      (vol)
    );

    assign vol_ll = vol[MIX_LL];
    assign vol_lr = vol[MIX_LR];
    assign vol_rl = vol[MIX_RL];
    assign vol_rr = vol[MIX_RR];

    // ---------------------------------------------------------------
    // Read mux
    // ---------------------------------------------------------------
    logic [7:0] status;
    logic [7:0] port_c_rd;

    assign status = {dat_full, !dat_empty, !rsp_empty, !par_full,
                     par_empty, rsp_full, bank_q};

    always_comb begin
        unique case (bank_q)
            BK_CTRL, BK_MIXA: port_c_rd = {{(8-IRQ_W){1'b0}}, irq_en};
            BK_IRQ,  BK_MIXB: port_c_rd = {{(8-IRQ_W){1'b0}}, irq_flag};
        endcase
    end

    always_comb begin
        unique case (host_sel)
            PORT_IDX: host_rdata = status;
            PORT_A:   host_rdata = rsp_head;
            PORT_B:   host_rdata = dat_head;
            PORT_C:   host_rdata = port_c_rd;
        endcase
    end

endmodule

// File: rtl/odc_host_regs_chk.sv
module odc_host_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] host_sel,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic       cmd_valid,
    input logic [7:0] cmd_byte,
    input logic       req_valid,
    input logic [7:0] req_byte,
    input logic [4:0] irq_set,
    input logic       irq,
    input logic [7:0] vol_ll,
    input logic [7:0] vol_lr,
    input logic [7:0] vol_rl,
    input logic [7:0] vol_rr,
    input logic [1:0] bank,
    input logic [4:0] en,
    input logic [4:0] flag
);
    logic cmd_wr, req_wr, clr_wr, apply_wr;

    assign cmd_wr   = host_wr && host_sel == 2'd1 && bank == 2'd0;
    assign req_wr   = host_wr && host_sel == 2'd3 && bank == 2'd0;
    assign clr_wr   = host_wr && host_sel == 2'd3 && bank == 2'd1;
    assign apply_wr = host_wr && host_sel == 2'd3 && bank == 2'd3 && host_wdata[5];

    a_r2_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_sel == 2'd0 |=> bank == $past(host_wdata[1:0]));

    a_r4_cmd_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> cmd_valid && cmd_byte == $past(host_wdata));

    a_r4_cmd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> !cmd_valid);

    a_r12_req_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        req_wr |=> req_valid && req_byte == $past(host_wdata));

    a_r12_req_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_wr |=> !req_valid);

    a_r11_vol_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !apply_wr |=> $stable(vol_ll) && $stable(vol_lr) && $stable(vol_rl) && $stable(vol_rr));

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && irq_set == '0 |=> (flag & $past(host_wdata[4:0])) == '0);

    a_r9_set: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set != '0 |=> (flag & $past(irq_set)) == $past(irq_set));

    a_r10_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0 || flag == '0) |-> !irq);

endmodule

bind odc_host_regs odc_host_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (cmd_byte),
    .req_valid  (req_valid),
    .req_byte   (req_byte),
    .irq_set    (irq_set),
    .irq        (irq),
    .vol_ll     (vol_ll),
    .vol_lr     (vol_lr),
    .vol_rl     (vol_rl),
    .vol_rr     (vol_rr),
    .bank       (bank_q),
    .en         (irq_en),
    .flag       (irq_flag)
);

// File: tb/odc_host_regs_tb.sv
module odc_host_regs_tb_top;
    localparam int CLK_P = 10;
    localparam int PAR_D = 16;
    localparam int RSP_D = 16;
    localparam int DAT_D = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] host_sel = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       cmd_valid, req_valid, par_avail, irq;
    logic [7:0] cmd_byte, req_byte, par_byte;
    logic       par_pop = 1'b0, rsp_push = 1'b0, dat_push = 1'b0;
    logic [7:0] rsp_byte = '0, dat_byte = '0;
    logic [4:0] irq_set = '0;
    logic [7:0] vol_ll, vol_lr, vol_rl, vol_rr;

    always #(CLK_P/2) clk = ~clk;

    odc_host_regs dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .req_valid(req_valid),
        .req_byte(req_byte), .par_pop(par_pop), .par_avail(par_avail),
        .par_byte(par_byte), .rsp_push(rsp_push), .rsp_byte(rsp_byte),
        .dat_push(dat_push), .dat_byte(dat_byte), .irq_set(irq_set), .irq(irq),
        .vol_ll(vol_ll), .vol_lr(vol_lr), .vol_rl(vol_rl), .vol_rr(vol_rr)
    );

    // ---------------- model ----------------
    int         total = 0, bad = 0;
    bit         finished = 0;
    logic [1:0] m_bank = 0;
    logic [4:0] m_en = 0, m_flag = 0;
    logic [7:0] m_stage [4];
    logic [7:0] m_act [4];
    logic [7:0] q_par [$];
    logic [7:0] q_rsp [$];
    logic [7:0] q_dat [$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {q_dat.size() == DAT_D, q_dat.size() != 0, q_rsp.size() != 0,
                q_par.size() < PAR_D, q_par.size() == 0, q_rsp.size() == RSP_D, m_bank};
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] sel);
        case (sel)
            2'd0: return exp_status();
            2'd1: return q_rsp.size() != 0 ? q_rsp[0] : 8'h00;
            2'd2: return q_dat.size() != 0 ? q_dat[0] : 8'h00;
            default: return m_bank[0] ? {3'b000, m_flag} : {3'b000, m_en};
        endcase
    endfunction

    function automatic string read_tag(input logic [1:0] sel);
        case (sel)
            2'd0: return "R3";
            2'd1: return "R6";
            2'd2: return "R7";
            default: return m_bank[0] ? "R9" : "R8";
        endcase
    endfunction

    task automatic check_side();
        chk("R11", {vol_ll, vol_lr, vol_rl, vol_rr}, {m_act[0], m_act[1], m_act[2], m_act[3]});
        chk("R10", irq, |(m_flag & m_en));
        chk("R5", par_avail, q_par.size() != 0);
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [7:0] d);
        bit exp_cmd = 0, exp_req = 0;
        @(negedge clk);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        case (sel)
            2'd0: m_bank = d[1:0];
            2'd1: if (m_bank == 0) exp_cmd = 1; else if (m_bank == 3) m_stage[3] = d;
            2'd2: case (m_bank)
                      2'd0: if (q_par.size() < PAR_D) q_par.push_back(d);
                      2'd1: m_en = d[4:0];
                      2'd2: m_stage[0] = d;
                      default: m_stage[2] = d;
                  endcase
            default: case (m_bank)
                      2'd0: exp_req = 1;
                      2'd1: m_flag = m_flag & ~d[4:0];
                      2'd2: m_stage[1] = d;
                      default: if (d[5]) for (int i = 0; i < 4; i++) m_act[i] = m_stage[i];
                  endcase
        endcase
        @(negedge clk);
        host_wr = 1'b0;
        chk("R4", cmd_valid, exp_cmd);
        if (exp_cmd) chk("R4", cmd_byte, d);
        chk("R12", req_valid, exp_req);
        if (exp_req) chk("R12", req_byte, d);
        check_side();
    endtask

    task automatic host_read(input logic [1:0] sel);
        @(negedge clk);
        host_sel = sel; host_rd = 1'b1;
        #1;
        chk(read_tag(sel), host_rdata, exp_read(sel));
        if (sel == 2'd1 && q_rsp.size() != 0) void'(q_rsp.pop_front());
        if (sel == 2'd2 && q_dat.size() != 0) void'(q_dat.pop_front());
        @(negedge clk);
        host_rd = 1'b0;
        check_side();
    endtask

    task automatic drv_rsp(input logic [7:0] b);
        @(negedge clk);
        rsp_push = 1'b1; rsp_byte = b;
        if (q_rsp.size() < RSP_D) q_rsp.push_back(b);
        @(negedge clk);
        rsp_push = 1'b0;
    endtask

    task automatic drv_dat(input logic [7:0] b);
        @(negedge clk);
        dat_push = 1'b1; dat_byte = b;
        if (q_dat.size() < DAT_D) q_dat.push_back(b);
        @(negedge clk);
        dat_push = 1'b0;
    endtask

    task automatic drv_par_pop();
        @(negedge clk);
        par_pop = 1'b1;
        #1;
        chk("R5", par_byte, q_par.size() != 0 ? q_par[0] : 8'h00);
        if (q_par.size() != 0) void'(q_par.pop_front());
        @(negedge clk);
        par_pop = 1'b0;
        check_side();
    endtask

    task automatic drv_irq(input logic [4:0] m);
        @(negedge clk);
        irq_set = m;
        m_flag = m_flag | m;
        @(negedge clk);
        irq_set = '0;
        check_side();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        total++; bad++;
        $display("FAIL watchdog act=running exp=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) begin m_stage[i] = 0; m_act[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", {cmd_valid, req_valid, irq}, 3'b000);
        chk("R1", {vol_ll, vol_lr, vol_rl, vol_rr}, 32'h0);
        host_read(2'd0);
        chk("R1", exp_status(), 8'h18);

        // R2 index write, upper bits ignored
        host_write(2'd0, 8'hFF);
        host_read(2'd0);
        chk("R2", m_bank, 2'd3);
        host_write(2'd0, 8'hFC);
        host_read(2'd0);

        // R4 command, and ignored port 1 writes in banks 1, 2
        host_write(2'd1, 8'hA5);
        host_write(2'd0, 8'd1); host_write(2'd1, 8'h11);
        host_write(2'd0, 8'd2); host_write(2'd1, 8'h22);
        host_write(2'd0, 8'd0);
        // R12 request
        host_write(2'd3, 8'h5A);

        // R5 parameter FIFO overflow and underflow
        for (int i = 0; i < PAR_D + 1; i++) host_write(2'd2, 8'(8'h40 + i));
        host_read(2'd0);
        for (int i = 0; i < PAR_D + 1; i++) drv_par_pop();

        // R6 response FIFO, read in bank 2
        host_write(2'd0, 8'd2);
        for (int i = 0; i < RSP_D + 1; i++) drv_rsp(8'(8'h80 + i));
        host_read(2'd0);
        for (int i = 0; i < RSP_D + 1; i++) host_read(2'd1);

        // R7 data FIFO
        for (int i = 0; i < DAT_D + 1; i++) drv_dat(8'(8'hC0 + i));
        host_read(2'd0);
        for (int i = 0; i < DAT_D + 1; i++) host_read(2'd2);

        // R8 R9 R10 interrupts
        host_write(2'd0, 8'd1);
        host_write(2'd2, 8'hFF);
        drv_irq(5'b10100);
        host_read(2'd3);
        host_write(2'd3, 8'h04);
        host_write(2'd3, 8'h10);
        host_write(2'd0, 8'd0);
        host_read(2'd3);

        // R11 staged volumes, apply without bit 5 ignored
        host_write(2'd0, 8'd2);
        host_write(2'd2, 8'h12); host_write(2'd3, 8'h34);
        host_write(2'd0, 8'd3);
        host_write(2'd2, 8'h56); host_write(2'd1, 8'h78);
        host_write(2'd3, 8'hDF);
        host_write(2'd3, 8'h20);

        // constrained random mix
        for (int n = 0; n < 1500; n++) begin
            int unsigned op = $urandom % 8;
            case (op)
                0, 1:    host_write(2'($urandom), 8'($urandom));
                2, 3:    host_read(2'($urandom));
                4:       drv_rsp(8'($urandom));
                5:       drv_dat(8'($urandom));
                6:       drv_par_pop();
                default: drv_irq(5'($urandom));
            endcase
        end
        finish_run();
    end

endmodule